// File: doc/BRIEF.md
# Serial SAR Converter Frame Master

This block is a synchronous master for a four-input serial successive-approximation converter on a four-wire link: an active-low select, a serial clock, a data line toward the converter and a data line back from it. A start request opens a frame. Chip select falls, and this also makes the converter sample its input and begin converting. Over sixteen serial clock periods the master shifts a 16-bit control word out, most significant bit first. On the same periods it shifts a 16-bit result word in. The conversion is timed by the serial clock, so there is no pipeline delay: each frame returns the sample taken at its own select edge.

The serial clock comes from the system clock through a half-period divider. The divider is derived from a system frequency parameter so that the serial clock never exceeds its ceiling. Between frames the master keeps select high for a minimum quiet time. After a wake pulse, which tells it that the converter is leaving shutdown, it holds off for a power-up time. Requests that arrive during a wait or a frame are remembered and served afterwards. Each received word becomes a 2-bit channel tag, a raw 12-bit code and the coding flag that was in force for that frame. These are presented on a valid/ready output.

Top module: `adc_ser_ctrl`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o is high and res_valid_o is low.
- R2: A frame holds cs_n_o low across exactly 16 falling edges of sclk_o. cs_n_o rises only after the sixteenth, and sclk_o is high whenever cs_n_o is high.
- R3: Every phase of sclk_o inside a frame, including the first high phase after cs_n_o falls, lasts HALF_CYC system cycles, where HALF_CYC = ceil(SYS_HZ / (2*SCLK_MAX_HZ)). The serial clock therefore stays at or below SCLK_MAX_HZ with a 50/50 duty cycle.
- R4: The control word latched at frame start goes out on mosi_o most significant bit first. mosi_o changes only when cs_n_o falls or sclk_o rises, so it is steady across every falling edge.
- R5: miso_i is sampled in the last system cycle before each of the 16 falling edges, giving a 16-bit word, first bit most significant. Bits 13:12 become res_chan_o and bits 11:0 become res_code_o. Bits 15:14 have no effect on the outputs.
- R6: twos_i is latched when a frame starts and is returned on res_twos_o with that frame's result.
- R7: cs_n_o stays high for at least QUIET_CYC = ceil(SYS_HZ * QUIET_NS / 1e9) system cycles between frames.
- R8: cs_n_o does not fall within PWRUP_CYC = ceil(SYS_HZ * PWRUP_NS / 1e9) system cycles after a cycle with wake_i high.
- R9: A start_i pulse during a frame or a wait is held and served once the wait ends. Several pulses before the frame begins give a single frame.
- R10: res_valid_o stays high with its payload unchanged until res_ready_i is high. No new frame begins while a result is unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| wake_i | input | 1 | Converter is leaving shutdown; begin power-up wait |
| ctrl_word_i | input | 16 | Control word sent in the next frame |
| twos_i | input | 1 | Coding flag attached to the next frame's result |
| cs_n_o | output | 1 | Chip select to converter, active low |
| sclk_o | output | 1 | Serial clock to converter, idles high |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data from converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_chan_o | output | 2 | Channel tag of the result |
| res_code_o | output | 12 | Raw conversion code |
| res_twos_o | output | 1 | Coding flag of the result |

## Verification
The bench keeps the default parameters: a 250 MHz system clock with a 20 MHz ceiling, 50 ns quiet time and 1000 ns power-up. These give a half period of 7 cycles, a quiet time of 13 cycles and a power-up wait of 250 cycles. A frame is then 224 cycles long, so back-to-back frames, a full power-up hold-off and a held request blocked by an unread result all fit into a few thousand cycles. A behavioural converter answers each frame with a chosen word, including words with nonzero upper bits, and records the bits captured on the falling edges.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CODE_W = 12;
  localparam int TAG_W = 2;

  typedef struct packed {
    logic [TAG_W-1:0]  chan;
    logic [CODE_W-1:0] code;
    logic              twos;
  } adc_res_t;

  function automatic int ceil_div(longint num, longint den);
    return int'((num + den - 1) / den);
  endfunction

  // system cycles per serial clock half period, never below one
  function automatic int half_cycles(longint sys_hz, longint max_hz);
    int h;
    h = ceil_div(sys_hz, 2 * max_hz);
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int ns_to_cycles(longint sys_hz, longint ns);
    return ceil_div(sys_hz * ns, 64'd1_000_000_000);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // upper two bits of the received word are discarded
  function automatic adc_res_t split_word(logic [FRAME_BITS-1:0] w, logic twos);
    adc_res_t r;
    r.chan = w[CODE_W+TAG_W-1:CODE_W];
    r.code = w[CODE_W-1:0];
    r.twos = twos;
    return r;
  endfunction
endpackage

// File: rtl/adc_half_tick.sv
module adc_half_tick #(
  parameter int HALF_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  generate
    if (HALF_CYC == 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF_CYC - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int QUIET_CYC = 13,
  parameter int PWRUP_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_quiet,
  input  logic load_wake,
  output logic idle
);
  import adc_ser_pkg::*;
  localparam int TOPV = imax(QUIET_CYC, PWRUP_CYC);
  localparam int CW = $clog2(TOPV + 1);

  logic [CW-1:0] cnt;

  // a load only ever lengthens the remaining wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load_wake && cnt < CW'(PWRUP_CYC))
      cnt <= CW'(PWRUP_CYC);
    else if (load_quiet && cnt < CW'(QUIET_CYC))
      cnt <= CW'(QUIET_CYC);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/adc_frame_eng.sv
module adc_frame_eng #(
  parameter int HALF_CYC = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [15:0] ctrl_word,
  input  logic        miso_i,
  output logic        cs_n_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        active,
  output logic        frame_end,
  output logic [15:0] rx_word
);
  import adc_ser_pkg::*;
  localparam int NPH = 2 * FRAME_BITS;
  localparam int HW = $clog2(NPH);

  logic          tick;
  logic [HW-1:0] ph;
  logic [15:0]   tx;
  logic          fall_evt;
  logic          rise_evt;

  assign active = !cs_n_o;

  adc_half_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
  );

  // even phases are high (sample then fall), odd phases are low
  assign fall_evt  = tick && !ph[0];
  assign frame_end = tick && (ph == HW'(NPH - 1));
  assign rise_evt  = tick && ph[0] && !frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b1;
      mosi_o  <= 1'b0;
      tx      <= '0;
      rx_word <= '0;
      ph      <= '0;
    end else if (go && cs_n_o) begin
      cs_n_o  <= 1'b0;
      sclk_o  <= 1'b1;
      mosi_o  <= ctrl_word[15];
      tx      <= {ctrl_word[14:0], 1'b0};
      rx_word <= '0;
      ph      <= '0;
    end else if (fall_evt) begin
      sclk_o  <= 1'b0;
      rx_word <= {rx_word[14:0], miso_i};
      ph      <= ph + 1'b1;
    end else if (frame_end) begin
      sclk_o  <= 1'b1;
      cs_n_o  <= 1'b1;
      mosi_o  <= 1'b0;
      ph      <= '0;
    end else if (rise_evt) begin
      sclk_o  <= 1'b1;
      mosi_o  <= tx[15];
      tx      <= {tx[14:0], 1'b0};
      ph      <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/adc_ser_ctrl.sv
module adc_ser_ctrl #(
  parameter longint SYS_HZ      = 64'd250_000_000,
  parameter longint SCLK_MAX_HZ = 64'd20_000_000,
  parameter longint QUIET_NS    = 64'd50,
  parameter longint PWRUP_NS    = 64'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wake_i,
  input  logic [15:0] ctrl_word_i,
  input  logic        twos_i,
  output logic        cs_n_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        res_valid_o,
  input  logic        res_ready_i,
  output logic [1:0]  res_chan_o,
  output logic [11:0] res_code_o,
  output logic        res_twos_o
);
  import adc_ser_pkg::*;
  localparam int HALF_CYC  = half_cycles(SYS_HZ, SCLK_MAX_HZ);
  localparam int QUIET_CYC = ns_to_cycles(SYS_HZ, QUIET_NS);
  localparam int PWRUP_CYC = ns_to_cycles(SYS_HZ, PWRUP_NS);

  logic        pending;
  logic        go;
  logic        active;
  logic        frame_end;
  logic        gap_idle;
  logic        twos_q;
  logic [15:0] rx_word;
  adc_res_t    res_q;

  assign go = pending && !active && gap_idle && !res_valid_o && !wake_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (go)      pending <= start_i;
    else if (start_i) pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  twos_q <= 1'b0;
    else if (go) twos_q <= twos_i;
  end

  adc_frame_eng #(.HALF_CYC(HALF_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .go(go), .ctrl_word(ctrl_word_i),
    .miso_i(miso_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .active(active), .frame_end(frame_end), .rx_word(rx_word)
  );

  adc_gap_timer #(.QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_quiet(frame_end), .load_wake(wake_i),
    .idle(gap_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_q       <= '0;
    end else if (frame_end) begin
      res_valid_o <= 1'b1;
      res_q       <= split_word(rx_word, twos_q);
    end else if (res_valid_o && res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

  assign res_chan_o = res_q.chan;
  assign res_code_o = res_q.code;
  assign res_twos_o = res_q.twos;
endmodule

module adc_ser_ctrl_chk #(
  parameter int QUIET_CYC = 13,
  parameter int PWRUP_CYC = 250
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n_o,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        wake_i,
  input logic        res_valid_o,
  input logic        res_ready_i,
  input logic [1:0]  res_chan_o,
  input logic [11:0] res_code_o
);
  int hi_cnt;
  int nfall;
  int wk;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= QUIET_CYC;
      nfall  <= 0;
      wk     <= 0;
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk_o;
      if (!cs_n_o)               hi_cnt <= 0;
      else if (hi_cnt < QUIET_CYC) hi_cnt <= hi_cnt + 1;
      if (cs_n_o)                nfall <= 0;
      else if (sclk_q && !sclk_o) nfall <= nfall + 1;
      if (wake_i)                wk <= PWRUP_CYC;
      else if (wk != 0)          wk <= wk - 1;
    end
  end

  // R2
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R2
  sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> nfall == 16);

  // R4
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $fell(sclk_o)) |-> $stable(mosi_o));

  // R7
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> hi_cnt >= QUIET_CYC);

  // R8
  powerup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> wk == 0);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_code_o) && $stable(res_chan_o)));

  // R10
  no_frame_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(res_valid_o));
endmodule

bind adc_ser_ctrl adc_ser_ctrl_chk #(.QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .wake_i(wake_i), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
  .res_chan_o(res_chan_o), .res_code_o(res_code_o)
);

// File: tb/adc_ser_ctrl_test.sv
module adc_ser_ctrl_test;
  // expected constants restated from the requirements for 250 MHz / 20 MHz
  localparam int EXP_HALF  = 7;    // ceil(250e6 / 40e6)
  localparam int EXP_QUIET = 13;   // ceil(250e6 * 50e-9)
  localparam int EXP_PWRUP = 250;  // ceil(250e6 * 1e-6)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, wake_i = 1'b0, twos_i = 1'b0, miso_i = 1'b0, res_ready_i = 1'b0;
  logic [15:0] ctrl_word_i = '0;
  logic cs_n_o, sclk_o, mosi_o, res_valid_o, res_twos_o;
  logic [1:0] res_chan_o;
  logic [11:0] res_code_o;

  int n_chk = 0, n_bad = 0;

  adc_ser_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wake_i(wake_i),
    .ctrl_word_i(ctrl_word_i), .twos_i(twos_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .res_valid_o(res_valid_o),
    .res_ready_i(res_ready_i), .res_chan_o(res_chan_o), .res_code_o(res_code_o),
    .res_twos_o(res_twos_o)
  );

  always #2 clk = ~clk;

  // converter model
  logic [15:0] model_resp = '0, m_word = '0, seen_ctrl = '0;
  int m_k = 0;
  always @(negedge cs_n_o) begin
    m_word = model_resp; m_k = 0; seen_ctrl = '0; miso_i = m_word[15];
  end
  always @(negedge sclk_o) if (!cs_n_o) begin
    seen_ctrl = {seen_ctrl[14:0], mosi_o};
    m_k++;
    if (m_k < 16) miso_i = m_word[15 - m_k];
  end

  // port monitor
  int hi_cnt = 1000, last_gap = 0, n_frames = 0, ph_cnt = 0, ph_min = 0, ph_max = 0, n_fall = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (cs_prev && !cs_n_o) begin
      last_gap = hi_cnt; hi_cnt = 0; n_frames++;
      ph_cnt = 1; ph_min = 9999; ph_max = 0; n_fall = 0;
    end else begin
      if (cs_n_o) hi_cnt++;
      if (!cs_prev) begin
        if (sclk_o != sclk_prev) begin
          if (ph_cnt < ph_min) ph_min = ph_cnt;
          if (ph_cnt > ph_max) ph_max = ph_cnt;
          if (!sclk_o) n_fall++;
          ph_cnt = 1;
        end else ph_cnt++;
      end
    end
    cs_prev = cs_n_o; sclk_prev = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000 && !res_valid_o; i++) @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); res_ready_i = 1'b1;
    @(negedge clk); res_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(cs_n_o === 1'b1, "R1 cs_n", cs_n_o, 1);
    chk(sclk_o === 1'b1, "R1 sclk", sclk_o, 1);
    chk(res_valid_o === 1'b0, "R1 valid", res_valid_o, 0);
  endtask

  task automatic t_frame(input logic [15:0] ctrl, input logic [15:0] resp, input logic tw);
    @(negedge clk);
    ctrl_word_i = ctrl; twos_i = tw; model_resp = resp; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_valid();
    chk(res_valid_o === 1'b1, "R2 result arrives", res_valid_o, 1);
    chk(n_fall == 16, "R2 falling edges", n_fall, 16);
    chk(ph_min == EXP_HALF && ph_max == EXP_HALF, "R3 phase width", ph_max, EXP_HALF);
    chk(seen_ctrl == ctrl, "R4 control word", seen_ctrl, ctrl);
    chk(res_chan_o == resp[13:12], "R5 channel tag", res_chan_o, resp[13:12]);
    chk(res_code_o == resp[11:0], "R5 code", res_code_o, resp[11:0]);
    chk(res_twos_o == tw, "R6 coding flag", res_twos_o, tw);
    pulse_ready();
    chk(res_valid_o === 1'b0, "R10 valid drops", res_valid_o, 0);
  endtask

  task automatic t_back_to_back();
    int f0;
    for (int i = 0; i < 40; i++) @(negedge clk);
    f0 = n_frames;
    res_ready_i = 1'b1; model_resp = 16'h2345; ctrl_word_i = 16'h5A5A;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (cs_n_o) @(negedge clk);
    for (int i = 0; i < 20; i++) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R9 two requests during frame
    @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 800; i++) @(negedge clk);
    res_ready_i = 1'b0;
    chk(n_frames - f0 == 2, "R9 held requests give one frame", n_frames - f0, 2);
    chk(last_gap >= EXP_QUIET, "R7 quiet gap", last_gap, EXP_QUIET);
  endtask

  task automatic t_unread_hold();
    int f0;
    logic [11:0] c0;
    model_resp = 16'h1777; ctrl_word_i = 16'h0F0F;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_valid();
    f0 = n_frames; c0 = res_code_o;
    model_resp = 16'h3123;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 400; i++) @(negedge clk);
    chk(n_frames == f0, "R10 no frame while unread", n_frames, f0);
    chk(res_valid_o === 1'b1 && res_code_o == c0, "R10 result held", res_code_o, c0);
    pulse_ready();
    wait_valid();
    chk(n_frames == f0 + 1, "R9 held start served", n_frames, f0 + 1);
    chk(res_code_o == 12'h123 && res_chan_o == 2'd3, "R5 second result", res_code_o, 12'h123);
    pulse_ready();
  endtask

  task automatic t_wake();
    int k;
    for (int i = 0; i < 40; i++) @(negedge clk);
    model_resp = 16'h0ABC;
    wake_i = 1'b1; start_i = 1'b1;
    @(negedge clk); wake_i = 1'b0; start_i = 1'b0;
    k = 1;
    while (cs_n_o && k < 1000) begin @(negedge clk); k++; end
    chk(k > EXP_PWRUP, "R8 power-up wait", k, EXP_PWRUP + 1);
    chk(k <= EXP_PWRUP + 6, "R9 start held across wake", k, EXP_PWRUP + 2);
    wait_valid();
    chk(res_code_o == 12'hABC, "R5 code after wake", res_code_o, 12'hABC);
    pulse_ready();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(16'hA5C3, 16'h1ABC, 1'b0);
    t_frame(16'h0001, 16'h2FFF, 1'b1);
    t_frame(16'hFFFF, 16'h0000, 1'b0);
    t_frame(16'h8000, 16'hF555, 1'b1);  // R5 bits 15:14 set, must not show
    t_back_to_back();
    t_unread_hold();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule